// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt lines into one request line towards a processor. Each line is fixed at elaboration as edge-sensitive or level-sensitive by the parameter `KIND_MASK`, where a 1 in bit n makes line n edge-sensitive. A captured event is held in a status bit. A per-line enable bit gates that status bit into the pending set. The lowest-numbered pending line is reported as a vector that software reads.

Software reaches the block through eight 32-bit registers selected by a 3-bit word index. A write takes effect on the clock edge where `bus_we_i` is high. Read data is combinational from `bus_addr_i`. Line n always maps to bit n of every mask register. Bits at or above `NUM_SRC` read as zero.

A two-bit master mode is held in a four-state machine. The states are MODE_OFF (00), MODE_OUT (01: request line live, line capture frozen), MODE_HW (10: line capture live, request line held low) and MODE_FULL (11). A write to index 7 moves the machine to the state named by bits 1:0 of the written data, from any state, including the current one. With no such write the machine stays where it is. Reset enters MODE_OFF.

Top module: `vic_top`

## Requirements
- R1: After reset, status, enable and master mode read zero, the vector (index 6) reads 0xFFFFFFFF and `irq_o` is low.
- R2: With capture live (mode bit 1 set), an edge line's status bit sets on the clock edge where its input is first seen high. The bit stays set after the input falls, until a write to index 3 has a 1 in that bit.
- R3: With capture live, a level line's status bit is set on every edge where its input is high. A write to index 3 clears it only on an edge where the input is low.
- R4: With mode bit 1 clear, line inputs do not change status, and a write to index 0 loads status from the data. With mode bit 1 set, writes to index 0 are ignored.
- R5: A write to index 2 replaces the enable bits. A write to index 4 sets the enable bits marked by 1s and keeps the others. A write to index 5 clears the enable bits marked by 1s and keeps the others.
- R6: Index 1 reads the bitwise AND of status and enable.
- R7: Index 6 reads the number of the lowest-numbered pending line, zero-extended, or 0xFFFFFFFF when nothing is pending.
- R8: `irq_o` is high one clock after an edge where mode bit 0 is set and at least one line is pending, and low one clock after any other edge.
- R9: Indices 3, 4 and 5 read zero. Index 7 reads the current mode in bits 1:0.
- R10: A write to index 3 leaves status bits that have a 0 in the data unchanged. If an edge line's rising input and its acknowledge fall on the same edge, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt lines, synchronous to clk_i |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check these relations:
- status bits that are not acknowledged never drop;
- status is frozen while capture is off and no write touches it;
- the set-enable and clear-enable aliases act on exactly the marked bits;
- the vector names the lowest pending bit;
- the request line falls after a cycle with nothing pending.

The bench scenarios cover the rest: the difference between edge and level capture, and an acknowledge meeting a rising edge on the same cycle. They also show that status writes are ignored in the live modes, the one-cycle latency of `irq_o` after a mode change, and the read-back values of the write-only indices. The bench sweeps all 256 enable patterns and all 256 status patterns of an 8-line configuration, checking each one against arithmetic expectations.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;

    localparam int unsigned REG_W = 32;

    // Word index of each register; software depends on these positions.
    typedef enum logic [2:0] {
        IDX_STATUS  = 3'd0,
        IDX_PENDING = 3'd1,
        IDX_ENABLE  = 3'd2,
        IDX_ACK     = 3'd3,
        IDX_SETEN   = 3'd4,
        IDX_CLREN   = 3'd5,
        IDX_VECTOR  = 3'd6,
        IDX_MODE    = 3'd7
    } reg_idx_e;

    // Bit 1 = line capture live, bit 0 = request output live.
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_OUT  = 2'b01,
        MODE_HW   = 2'b10,
        MODE_FULL = 2'b11
    } mode_state_e;

endpackage

// File: rtl/vic_src_bank.sv
`timescale 1ns/1ps
module vic_src_bank #(
    parameter int unsigned NUM_SRC   = 32,
    parameter logic [31:0] KIND_MASK = 32'h0000_0000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               hw_en_i,
    input  logic [NUM_SRC-1:0] ack_i,
    input  logic               sw_wr_i,
    input  logic [NUM_SRC-1:0] sw_data_i,
    output logic [NUM_SRC-1:0] status_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        if (KIND_MASK[g]) begin : g_edge
            logic prev_q;
            logic rise;

            assign rise = src_i[g] & ~prev_q;

            // History tracks the line even while capture is frozen, so that
            // turning capture on never creates a false edge.
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) prev_q <= 1'b0;
                else         prev_q <= src_i[g];
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)                 status_o[g] <= 1'b0;
                else if (sw_wr_i)            status_o[g] <= sw_data_i[g];
                else if (hw_en_i && rise)    status_o[g] <= 1'b1;
                else if (ack_i[g])           status_o[g] <= 1'b0;
            end
        end else begin : g_level
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)                  status_o[g] <= 1'b0;
                else if (sw_wr_i)             status_o[g] <= sw_data_i[g];
                else if (hw_en_i && src_i[g]) status_o[g] <= 1'b1;
                else if (ack_i[g])            status_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vic_prio_enc.sv
`timescale 1ns/1ps
module vic_prio_enc #(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_mode_fsm.sv
`timescale 1ns/1ps
module vic_mode_fsm
    import vic_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mode_wr_i,
    input  logic [1:0] mode_data_i,
    input  logic       any_pend_i,
    output logic       hw_en_o,
    output logic       out_en_o,
    output logic [1:0] mode_o,
    output logic       irq_o
);

    mode_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (mode_wr_i) begin
            unique case (mode_data_i)
                2'b00: state_d = MODE_OFF;
                2'b01: state_d = MODE_OUT;
                2'b10: state_d = MODE_HW;
                2'b11: state_d = MODE_FULL;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= MODE_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MODE_OFF:  begin hw_en_o = 1'b0; out_en_o = 1'b0; end
            MODE_OUT:  begin hw_en_o = 1'b0; out_en_o = 1'b1; end
            MODE_HW:   begin hw_en_o = 1'b1; out_en_o = 1'b0; end
            MODE_FULL: begin hw_en_o = 1'b1; out_en_o = 1'b1; end
        endcase
        mode_o = state_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_o <= 1'b0;
        else         irq_o <= out_en_o & any_pend_i;
    end

endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 32,
    parameter logic [31:0] KIND_MASK = 32'h0000_0000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_we_i,
    input  logic [2:0]         bus_addr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    output logic               irq_o
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] wdata_src;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack_mask;
    logic               hw_en;
    logic               out_en;
    logic [1:0]         mode;
    logic               vec_found;
    logic [IDX_W-1:0]   vec_idx;
    logic               sts_wr;
    logic               mode_wr;

    assign wdata_src = bus_wdata_i[NUM_SRC-1:0];
    assign ack_mask  = (bus_we_i && bus_addr_i == IDX_ACK) ? wdata_src : '0;
    assign sts_wr    = bus_we_i && bus_addr_i == IDX_STATUS && !hw_en;
    assign mode_wr   = bus_we_i && bus_addr_i == IDX_MODE;
    assign pend      = status_q & enable_q;

    vic_src_bank #(
        .NUM_SRC   (NUM_SRC),
        .KIND_MASK (KIND_MASK)
    ) bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (src_i),
        .hw_en_i   (hw_en),
        .ack_i     (ack_mask),
        .sw_wr_i   (sts_wr),
        .sw_data_i (wdata_src),
        .status_o  (status_q)
    );

    vic_prio_enc #(
        .NUM_SRC (NUM_SRC)
    ) enc_i (
        .pend_i  (pend),
        .found_o (vec_found),
        .idx_o   (vec_idx)
    );

    vic_mode_fsm fsm_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_wr_i   (mode_wr),
        .mode_data_i (bus_wdata_i[1:0]),
        .any_pend_i  (vec_found),
        .hw_en_o     (hw_en),
        .out_en_o    (out_en),
        .mode_o      (mode),
        .irq_o       (irq_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            enable_q <= '0;
        end else if (bus_we_i) begin
            if (bus_addr_i == IDX_ENABLE)     enable_q <= wdata_src;
            else if (bus_addr_i == IDX_SETEN) enable_q <= enable_q | wdata_src;
            else if (bus_addr_i == IDX_CLREN) enable_q <= enable_q & ~wdata_src;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            IDX_STATUS:  bus_rdata_o[NUM_SRC-1:0] = status_q;
            IDX_PENDING: bus_rdata_o[NUM_SRC-1:0] = pend;
            IDX_ENABLE:  bus_rdata_o[NUM_SRC-1:0] = enable_q;
            IDX_ACK:     bus_rdata_o = '0;
            IDX_SETEN:   bus_rdata_o = '0;
            IDX_CLREN:   bus_rdata_o = '0;
            IDX_VECTOR: begin
                if (vec_found) bus_rdata_o[IDX_W-1:0] = vec_idx;
                else           bus_rdata_o = '1;
            end
            IDX_MODE:    bus_rdata_o[1:0] = mode;
            default:     bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/vic_top_chk.sv
`timescale 1ns/1ps
module vic_top_chk
    import vic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               bus_we_i,
    input logic [2:0]         bus_addr_i,
    input logic [REG_W-1:0]   bus_wdata_i,
    input logic               hw_en,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [NUM_SRC-1:0] pend,
    input logic               vec_found,
    input logic [IDX_W-1:0]   vec_idx,
    input logic               irq_o
);

    logic [NUM_SRC-1:0] wd;
    logic [NUM_SRC-1:0] ack_seen;
    logic [NUM_SRC-1:0] below_mask;
    logic               sts_touch;

    assign wd        = bus_wdata_i[NUM_SRC-1:0];
    assign ack_seen  = (bus_we_i && bus_addr_i == IDX_ACK) ? wd : '0;
    assign sts_touch = bus_we_i && bus_addr_i == IDX_STATUS;

    always_comb begin
        below_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i < int'(vec_idx)) below_mask[i] = 1'b1;
        end
    end

    // R2 / R10: a status bit never drops unless acknowledged or overwritten.
    p_status_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sts_touch |=> ((($past(status_q) & ~$past(ack_seen)) & ~status_q) == '0));

    // R4: capture off and no bus touch leaves status alone.
    p_hw_off_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hw_en && !sts_touch && ack_seen == '0) |=> $stable(status_q));

    // R5: set alias sets exactly the marked bits.
    p_set_alias_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == IDX_SETEN) |=> ((enable_q & $past(wd)) == $past(wd)));

    // R5: clear alias clears exactly the marked bits.
    p_clr_alias_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == IDX_CLREN) |=> ((enable_q & $past(wd)) == '0));

    // R7: the vector names the lowest pending bit.
    p_vec_lowest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_found |-> (pend[vec_idx] && ((pend & below_mask) == '0)));

    // R7: no vector when nothing pends.
    p_vec_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_found |-> (pend == '0));

    // R8: the request line falls after a cycle with nothing pending.
    p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_found |=> !irq_o);

endmodule

bind vic_top vic_top_chk #(
    .NUM_SRC (NUM_SRC)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .hw_en       (hw_en),
    .status_q    (status_q),
    .enable_q    (enable_q),
    .pend        (pend),
    .vec_found   (vec_found),
    .vec_idx     (vec_idx),
    .irq_o       (irq_o)
);

// File: tb/vic_top_tb_top.sv
`timescale 1ns/1ps
module vic_top_tb_top;

    localparam int unsigned N    = 8;
    localparam logic [31:0] KIND = 32'h0000_000F; // lines 0-3 edge, 4-7 level

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         we = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    vic_top #(.NUM_SRC(N), .KIND_MASK(KIND)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return 32'(i);
        return 32'hFFFF_FFFF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 status", v, 0);
        rd(3'd2, v); check("R1 enable", v, 0);
        rd(3'd7, v); check("R1 mode", v, 0);
        rd(3'd6, v); check("R1 vector", v, 32'hFFFF_FFFF);
        check("R1 irq", 32'(irq), 0);

        // R9 read-back
        wr(3'd7, 32'h3); rd(3'd7, v); check("R9 mode", v, 3);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R9 upper bits zero", v, 32'hFF);
        rd(3'd3, v); check("R9 ack reads zero", v, 0);
        rd(3'd4, v); check("R9 set reads zero", v, 0);
        rd(3'd5, v); check("R9 clr reads zero", v, 0);

        // R5 sweep of every enable pattern through all three write paths
        for (int m = 0; m < 256; m++) begin
            logic [7:0] e, n, k;
            e = 8'(m); n = 8'(m * 37); k = 8'(m * 91 + 5);
            wr(3'd2, 32'(e)); rd(3'd2, v); check("R5 replace", v, 32'(e));
            wr(3'd4, 32'(n)); rd(3'd2, v); check("R5 set alias", v, 32'(e | n));
            wr(3'd5, 32'(k)); rd(3'd2, v); check("R5 clr alias", v, 32'((e | n) & ~k));
        end

        // R4 capture frozen in output-only mode
        wr(3'd7, 32'h1);
        wr(3'd3, 32'hFF);
        @(negedge clk); src = 8'hFF;
        repeat (2) @(negedge clk);
        rd(3'd0, v); check("R4 lines ignored", v, 0);
        src = 8'h00;
        @(negedge clk);

        // R6/R7/R8 sweep of status patterns via software status writes
        for (int s = 0; s < 256; s++) begin
            logic [7:0] st, en;
            st = 8'(s);
            wr(3'd0, 32'(st)); rd(3'd0, v); check("R4 status write", v, 32'(st));
            for (int j = 0; j < 3; j++) begin
                en = (j == 0) ? 8'hFF : (j == 1) ? 8'(s * 13 + 1) : 8'hF0;
                wr(3'd2, 32'(en));
                rd(3'd1, v); check("R6 pending", v, 32'(st & en));
                rd(3'd6, v); check("R7 vector", v, lowest(st & en));
                check("R8 irq level", 32'(irq), 32'((st & en) != 0));
            end
        end

        // Full mode: status writes ignored
        wr(3'd0, 32'h0);
        wr(3'd7, 32'h3);
        wr(3'd0, 32'hFF); rd(3'd0, v); check("R4 write ignored", v, 0);

        // R2 edge capture and hold
        wr(3'd2, 32'hFF);
        @(negedge clk); src[2] = 1'b1;
        @(negedge clk); src[2] = 1'b0;
        rd(3'd0, v); check("R2 edge set", v, 32'h04);
        wr(3'd3, 32'hFB); rd(3'd0, v); check("R10 zero bits kept", v, 32'h04);
        wr(3'd3, 32'h04); rd(3'd0, v); check("R2 edge acked", v, 0);

        // R10 rise and ack on the same edge
        @(negedge clk);
        src[1] = 1'b1; we = 1'b1; addr = 3'd3; wdata = 32'h02;
        @(negedge clk);
        we = 1'b0;
        rd(3'd0, v); check("R10 rise wins", v, 32'h02);
        src[1] = 1'b0;
        wr(3'd3, 32'h02); rd(3'd0, v); check("R10 later ack", v, 0);

        // R3 level capture
        @(negedge clk); src[5] = 1'b1;
        @(negedge clk);
        rd(3'd0, v); check("R3 level set", v, 32'h20);
        wr(3'd3, 32'h20); rd(3'd0, v); check("R3 ack while high", v, 32'h20);
        src[5] = 1'b0;
        @(negedge clk);
        rd(3'd0, v); check("R3 held after drop", v, 32'h20);
        wr(3'd3, 32'h20); rd(3'd0, v); check("R3 ack after drop", v, 0);

        // R8 timing of the request line
        wr(3'd2, 32'h04);
        @(negedge clk); src[2] = 1'b1;
        @(negedge clk);
        check("R8 irq one cycle late", 32'(irq), 0);
        @(negedge clk);
        check("R8 irq raised", 32'(irq), 1);
        wr(3'd7, 32'h2);
        check("R8 irq after mode write", 32'(irq), 1);
        @(negedge clk);
        check("R8 irq dropped", 32'(irq), 0);
        src[2] = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule